// File: doc/BRIEF.md
# Split-Lane Data-Strobe Word Serializer

This block takes one parallel word at a time through a valid/ready handshake and sends it, one bit per clock, over a two-wire transition-coded pair. The pair consists of a level wire and a toggle wire. Every transmitted bit produces exactly one edge on the pair. The level wire always shows the bit value. The toggle wire flips instead whenever the new bit repeats the level already on the line. The parity of the two wires therefore alternates with every bit, and a receiver can recover a bit clock without a separate strobe.

Inside the block, the word is dealt across `LANES` interleaved shift registers. Bit i goes to lane i mod `LANES`. Each lane shifts only once every `LANES` bit times. A small merge stage visits the lanes in rotation, starting at lane 0, so the word leaves least significant bit first. Only the rotation pointer and the line encoder switch on every bit.

Flow control is per word. After the last bit is sent, the block waits for a single acknowledge from the far end before it takes the next word. The line encoder is never cleared between words: each word continues from the levels the previous word left on the wires.

Top module: `ds_split_serializer`

## Requirements
- R1: While reset is asserted and right after it is released, `line_s` and `line_p` are 0 and `in_ready` is 1.
- R2: For each bit, exactly one of `line_s` and `line_p` changes, on one clock edge. During the `WORD_W` edges that follow an accepted word, there is one such change per edge. Outside those edges, neither wire changes.
- R3: After each bit edge, `line_s` equals the value of the bit just sent.
- R4: `line_p` toggles exactly when the bit sent equals the previous `line_s` level. As a result, `line_s ^ line_p` flips on every bit.
- R5: The bits of an accepted word go out least significant bit first. Bit 0 appears on the edge right after the accepting edge, and bit `WORD_W-1` appears `WORD_W` edges after the accepting edge.
- R6: `in_ready` drops on the accepting edge (`in_valid && in_ready`). It stays 0 through all bits of the word and while waiting for the acknowledge.
- R7: `ack` is sampled only after the last bit has been sent. An `ack` raised earlier has no effect. An `ack` raised after the last bit returns `in_ready` to 1 on the next edge.
- R8: The encoder levels carry over from one word to the next. Reset is the only thing that returns them to 0.
- R9: `in_valid` while `in_ready` is 0 is ignored: that word is not sent, and the bits of the word in flight are not disturbed.
- R10: `WORD_W` must be a multiple of `LANES`. Elaboration fails otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block takes a word on this edge |
| in_word | input | WORD_W | Parallel word to send, bit 0 first |
| ack | input | 1 | Word-level acknowledge from the receiver |
| line_s | output | 1 | Level wire: carries the bit value |
| line_p | output | 1 | Toggle wire: flips when a bit repeats the level |

## Verification
A word accepted on edge E produces its bit k on edge E+1+k. `in_ready` is 0 when sampled after edge E+`WORD_W`. It returns to 1 one edge after `ack` is applied. The bench samples on falling edges. A monitor pops the next expected wire pair from a scoreboard queue whenever the pair has changed since the previous falling edge. The driver checks, after the (E+`WORD_W`)-th edge, that the queue has been drained. Early acknowledges and offers made while busy are applied in the middle of a word, and their lack of effect is then read back from the line and from `in_ready`.

// File: rtl/ds_ser_pkg.sv
package ds_ser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } ser_state_e;

endpackage

// File: rtl/ds_lane_bank.sv
module ds_lane_bank #(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic [LANES-1:0]  shift_en,
  output logic [LANES-1:0]  lane_lsb
);

  localparam int LANE_D = WORD_W / LANES;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_D-1:0] lane_q;
    logic [LANE_D-1:0] lane_d;
    logic [LANE_D-1:0] load_val;
    logic              lane_ce;

    for (genvar k = 0; k < LANE_D; k++) begin : g_pick
      assign load_val[k] = load_word[k*LANES + j];
    end

    assign lane_ce = load_en | shift_en[j];

    always_comb begin
      lane_d = lane_q;
      if (load_en) begin
        lane_d = load_val;
      end else if (shift_en[j]) begin
        lane_d = {1'b0, lane_q[LANE_D-1:1]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_ce) begin
        lane_q <= lane_d;
      end
    end

    assign lane_lsb[j] = lane_q[0];

    // R6: a lane is never reloaded while it is being shifted
    p_no_load_during_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en[j] |-> !load_en);
  end

endmodule

// File: rtl/ds_merge_stage.sv
module ds_merge_stage #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             send,
  input  logic [LANES-1:0] lane_lsb,
  output logic [LANES-1:0] shift_en,
  output logic             bit_out
);

  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(LANES - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_ce;

  assign ptr_ce = start | send;

  always_comb begin
    ptr_d = ptr_q;
    if (start) begin
      ptr_d = '0;
    end else if (send) begin
      ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ce) begin
      ptr_q <= ptr_d;
    end
  end

  always_comb begin
    shift_en = '0;
    bit_out  = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (ptr_q == PTR_W'(j)) begin
        bit_out     = lane_lsb[j];
        shift_en[j] = send;
      end
    end
  end

  // R5: rotation advances exactly one lane per sent bit
  p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !start) |=> (ptr_q == (($past(ptr_q) == PTR_LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R2: at most one lane shifts in a cycle
  p_single_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(shift_en));

endmodule

// File: rtl/ds_ledr_encoder.sv
module ds_ledr_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic line_s,
  output logic line_p
);

  logic s_q, s_d;
  logic p_q, p_d;

  always_comb begin
    s_d = bit_in;
    p_d = (bit_in == s_q) ? ~p_q : p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      p_q <= 1'b0;
    end else if (bit_vld) begin
      s_q <= s_d;
      p_q <= p_d;
    end
  end

  assign line_s = s_q;
  assign line_p = p_q;

  // R2: one edge per bit, on exactly one wire
  p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> ((line_s != $past(line_s)) != (line_p != $past(line_p))));

  // R2: quiet line when no bit is sent
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> ($stable(line_s) && $stable(line_p)));

  // R3: level wire follows the bit
  p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> (line_s == $past(bit_in)));

  // R4: wire parity flips on every bit
  p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> ((line_s ^ line_p) != $past(line_s ^ line_p)));

endmodule

// File: rtl/ds_word_ctrl.sv
module ds_word_ctrl
  import ds_ser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic ack,
  output logic in_ready,
  output logic load_en,
  output logic send
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  ser_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign in_ready = (state_q == ST_IDLE);
  assign load_en  = in_ready & in_valid;
  assign send     = (state_q == ST_SEND);
  assign cnt_ce   = load_en | send;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_SEND;
          cnt_d   = '0;
        end
      end
      ST_SEND: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ack) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  // R7: waiting holds until the acknowledge
  p_hold_for_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !ack) |=> (state_q == ST_WAIT));

  // R7: an acknowledge while sending does not cut the word short
  p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (send && cnt_q != CNT_LAST) |=> send);

  // R6: an accepted word is followed by a sending phase
  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (send && !in_ready));

endmodule

// File: rtl/ds_split_serializer.sv
module ds_split_serializer #(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              ack,
  output logic              line_s,
  output logic              line_p
);

  // R10: word must split evenly across lanes
  if ((WORD_W % LANES) != 0 || LANES < 1) begin : g_bad_split
    $error("WORD_W must be a multiple of LANES (R10)");
  end

  logic             load_en;
  logic             send;
  logic [LANES-1:0] shift_en;
  logic [LANES-1:0] lane_lsb;
  logic             merged_bit;

  ds_word_ctrl #(
    .WORD_W (WORD_W)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .ack      (ack),
    .in_ready (in_ready),
    .load_en  (load_en),
    .send     (send)
  );

  ds_lane_bank #(
    .WORD_W (WORD_W),
    .LANES  (LANES)
  ) lanes_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_word (in_word),
    .shift_en  (shift_en),
    .lane_lsb  (lane_lsb)
  );

  ds_merge_stage #(
    .LANES (LANES)
  ) merge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (load_en),
    .send     (send),
    .lane_lsb (lane_lsb),
    .shift_en (shift_en),
    .bit_out  (merged_bit)
  );

  ds_ledr_encoder enc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (send),
    .bit_in  (merged_bit),
    .line_s  (line_s),
    .line_p  (line_p)
  );

  // R9: no word is taken while one is in flight
  p_busy_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> !in_ready);

endmodule

// File: tb/ds_split_serializer_tb_top.sv
module ds_split_serializer_tb_top;

  localparam int WORD_W = 16;
  localparam int LANES  = 4;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [WORD_W-1:0] in_word;
  logic              ack;
  logic              line_s;
  logic              line_p;

  int n_cmp;
  int n_bad;

  logic [1:0] exp_q[$];
  logic       mdl_s;
  logic       mdl_p;
  logic       prev_s;
  logic       prev_p;
  logic       mon_on;

  ds_split_serializer #(.WORD_W(WORD_W), .LANES(LANES)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_word  (in_word),
    .ack      (ack),
    .line_s   (line_s),
    .line_p   (line_p)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop on every observed line change
  always @(negedge clk) begin
    if (mon_on) begin
      if (line_s != prev_s || line_p != prev_p) begin
        check(!((line_s != prev_s) && (line_p != prev_p)), "R2 single wire edge",
              {30'd0, line_s, line_p}, {30'd0, prev_s, prev_p});
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected line change", {30'd0, line_s, line_p}, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check(line_s == e[1], "R3 level wire", int'(line_s), int'(e[1]));
          check(line_p == e[0], "R4 toggle wire", int'(line_p), int'(e[0]));
        end
      end
      prev_s = line_s;
      prev_p = line_p;
    end
  end

  // driver: offer word, push expectations, optionally ack early or offer while busy
  task automatic send_word(input logic [WORD_W-1:0] w, input bit early_ack, input bit busy_offer);
    @(negedge clk);
    check(in_ready == 1'b1, "R6 ready before word", int'(in_ready), 1);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    for (int i = 0; i < WORD_W; i++) begin
      logic b;
      b = w[i];
      if (b == mdl_s) mdl_p = ~mdl_p;
      mdl_s = b;
      exp_q.push_back({mdl_s, mdl_p});
    end
    #1;
    in_valid = 1'b0;
    in_word  = ~w;
    for (int c = 1; c <= WORD_W; c++) begin
      @(posedge clk);
      #1;
      if (c == 1) begin
        check(exp_q.size() == WORD_W, "R5 first bit not yet popped", exp_q.size(), WORD_W);
      end
      if (early_ack) ack = (c == 4 || c == WORD_W - 1);
      if (busy_offer) in_valid = (c >= 3 && c < 9);
      if (c == 6) check(in_ready == 1'b0, "R6 ready low mid word", int'(in_ready), 0);
    end
    ack      = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    check(exp_q.size() == 0, "R5 all bits out by edge WORD_W", exp_q.size(), 0);
    check(in_ready == 1'b0, "R7 waits for ack after word", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready == 1'b0, "R7 still waiting without ack", int'(in_ready), 0);
    check(line_s == mdl_s && line_p == mdl_p, "R2 line quiet while waiting",
          {30'd0, line_s, line_p}, {30'd0, mdl_s, mdl_p});
    ack = 1'b1;
    @(posedge clk);
    #1;
    ack = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R7 ready after ack", int'(in_ready), 1);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    mon_on = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    ack = 1'b0;
    mdl_s = 1'b0;
    mdl_p = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(line_s == 1'b0 && line_p == 1'b0, "R1 reset line levels",
          {30'd0, line_s, line_p}, 0);
    check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    prev_s = line_s;
    prev_p = line_p;
    mon_on = 1'b1;

    send_word(16'hA5C3, 1'b0, 1'b0);   // R3 R4 mixed pattern
    send_word(16'h0000, 1'b0, 1'b0);   // R4 repeated zeros toggle P
    send_word(16'hFFFF, 1'b0, 1'b0);   // R8 continues from previous levels
    send_word(16'h8001, 1'b1, 1'b0);   // R7 early ack ignored
    send_word(16'h1234, 1'b0, 1'b1);   // R9 offer while busy ignored

    // R9: the word offered while busy must not have been sent
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 no stray word", exp_q.size(), 0);
    check(line_s == mdl_s && line_p == mdl_p, "R8 R9 levels held",
          {30'd0, line_s, line_p}, {30'd0, mdl_s, mdl_p});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule